// File: doc/BRIEF.md
# Three-Phase Complementary PWM Generator

This block drives three complementary pairs of PWM outputs for a three-phase bridge. A leading counter and a trailing counter run in lockstep, up and then down, with the leading counter ahead of the trailing one by a programmable dead time. Each phase compares its duty value against both counters. The positive output takes its edges from the trailing counter and the negative output takes its edges from the leading counter. Because of this, the two outputs of a pair are never active together, and every switch-over has a gap of exactly the dead time.

Software sets the block up through a write-only register port while the counters are halted. After counting starts, new duty values and a new half-period are written to buffer registers. These buffered values move into the active registers each time the carrier turns, at the crest and at the trough. The block raises a one-cycle interrupt pulse when the leading counter reaches its upper limit, and it can flip a cycle-marker output once per carrier period. The write port is a plain control interface with no back-pressure: a write takes effect on the clock edge where `wr_en` is high, and there is no ready signal. No data stream passes through the block.

Top module: `cpwm3_top`

## Requirements
- R1: After reset the counters are halted, every PWM pin is high (polarity bits reset to 0, which means active-low, so high is the inactive level), and `irq` and `cyc_tog` are low.
- R2: A start write loads the leading counter with the dead time and the trailing counter with 0. The counters then move one step every DIV clocks. The trailing counter climbs 0..H, where H is the active half-period, and falls back to 0. It turns one step after it reaches each extreme, so one carrier period is 2H steps. While running, the leading counter stays exactly dead-time above the trailing counter. While halted, both counters hold their values.
- R3: For each phase with duty value D, the positive output is active while trailing >= D and the negative output is active while leading < D. The two outputs of a pair are never active at the same time.
- R4: The positive polarity bit (MODE bit 1) and the negative polarity bit (MODE bit 2) set the active level of their outputs: 1 means active-high and 0 means active-low.
- R5: When the master enable (OUTEN bit 0) is 0, or when the counters are halted, all six PWM pins sit at their inactive level.
- R6: A duty write (addresses 5, 6, 7 for phases 0, 1, 2) or a half-period write (address 3) always loads the buffer register. While halted, the same write also loads the active register. While running, the buffers move into the active registers only on the step that leaves the crest and on the step that leaves the trough.
- R7: Writes to MODE (address 1) and DEAD (address 2) are ignored while the counters are running.
- R8: When OUTEN bit 1 is set, `irq` pulses high for exactly one clock as the leading counter reaches half-period plus dead time.
- R9: When MODE bit 0 is set, `cyc_tog` flips on every step that leaves the trough. A start write clears `cyc_tog` to 0.
- R10: Writing address 0 with bit 0 set to 1 starts the counters, and writing it with bit 0 set to 0 halts them. OUTEN is at address 4. Writes to OUTEN and to the buffers are accepted at any time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | CW | Register write data |
| pwm_p | output | PH | Positive output of each phase |
| pwm_n | output | PH | Negative (complementary) output of each phase |
| irq | output | 1 | One-clock pulse at the carrier crest |
| cyc_tog | output | 1 | Flips once per carrier period |

## Verification
The assertions check the following on every cycle:
- the two outputs of a pair are never active together;
- the counter gap equals the dead time while running;
- the pins are idle when halted or disabled;
- the interrupt is a single pulse that occurs only at the upper limit;
- the cycle marker changes only on a step or a start;
- the protected registers hold their values while running.

Only the directed scenarios can show the features that depend on timing over a whole carrier period. These are the exact step on which each pin changes for a given duty, the crest and trough steps at which buffered duties take effect, the polarity inversion, and the actual dropping of writes that arrive while counting.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;
  localparam int unsigned AW = 4;

  typedef enum logic [AW-1:0] {
    A_RUN   = 4'd0,
    A_MODE  = 4'd1,
    A_DEAD  = 4'd2,
    A_HALF  = 4'd3,
    A_OUTEN = 4'd4,
    A_DUTY0 = 4'd5
  } reg_addr_e;

  typedef struct packed {
    logic pol_n;
    logic pol_p;
    logic tog_en;
  } mode_t;
endpackage

// File: rtl/cpwm_regs.sv
module cpwm_regs
  import cpwm_pkg::*;
#(
  parameter int unsigned CW = 16,
  parameter int unsigned PH = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [AW-1:0]          wr_addr,
  input  logic [CW-1:0]          wr_data,
  input  logic                   xfer,
  output logic                   run,
  output logic                   start,
  output mode_t                  mode,
  output logic                   out_en,
  output logic                   irq_en,
  output logic [CW-1:0]          dead,
  output logic [CW-1:0]          half_act,
  output logic [PH-1:0][CW-1:0]  duty_act
);
  logic [CW-1:0] half_buf;
  logic [PH-1:0][CW-1:0] duty_buf;

  assign start = wr_en && (wr_addr == A_RUN) && wr_data[0] && !run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run      <= 1'b0;
      mode     <= '0;
      out_en   <= 1'b0;
      irq_en   <= 1'b0;
      dead     <= CW'(1);
      half_buf <= '0;
      half_act <= '0;
    end else begin
      if (xfer) half_act <= half_buf;
      if (wr_en) begin
        case (wr_addr)
          A_RUN:   run <= wr_data[0];
          A_MODE:  if (!run) mode <= mode_t'(wr_data[2:0]);
          A_DEAD:  if (!run) dead <= wr_data;
          A_HALF: begin
            half_buf <= wr_data;
            if (!run) half_act <= wr_data;
          end
          A_OUTEN: begin
            out_en <= wr_data[0];
            irq_en <= wr_data[1];
          end
          default: ;
        endcase
      end
    end
  end

  for (genvar i = 0; i < PH; i++) begin : g_duty
    logic hit;
    assign hit = wr_en && (wr_addr == AW'(int'(A_DUTY0) + i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        duty_buf[i] <= '0;
        duty_act[i] <= '0;
      end else begin
        if (hit) duty_buf[i] <= wr_data;
        if (hit && !run) duty_act[i] <= wr_data;
        else if (xfer && run) duty_act[i] <= duty_buf[i];
      end
    end
  end
endmodule

// File: rtl/cpwm_counter.sv
module cpwm_counter #(
  parameter int unsigned CW  = 16,
  parameter int unsigned DIV = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          start,
  input  logic [CW-1:0] dead,
  input  logic [CW-1:0] half,
  output logic [CW-1:0] c_lead,
  output logic [CW-1:0] c_trail,
  output logic          tick,
  output logic          crest_hit,
  output logic          trough_turn,
  output logic          xfer
);
  localparam int unsigned PW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [PW-1:0] pre;
  logic          up;
  logic [CW-1:0] upper;
  logic          at_crest, at_trough;

  assign upper     = half + dead;
  assign tick      = run && (pre == PW'(DIV - 1));
  assign at_crest  = up && (c_lead == upper);
  assign at_trough = !up && (c_trail == '0);
  assign xfer        = tick && (at_crest || at_trough);
  assign trough_turn = tick && at_trough;
  assign crest_hit   = tick && up && !at_crest && ((c_lead + CW'(1)) == upper);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre     <= '0;
      up      <= 1'b1;
      c_lead  <= '0;
      c_trail <= '0;
    end else if (start) begin
      pre     <= '0;
      up      <= 1'b1;
      c_lead  <= dead;
      c_trail <= '0;
    end else if (tick) begin
      pre <= '0;
      if (at_crest) begin
        up      <= 1'b0;
        c_lead  <= c_lead - CW'(1);
        c_trail <= c_trail - CW'(1);
      end else if (at_trough || up) begin
        up      <= 1'b1;
        c_lead  <= c_lead + CW'(1);
        c_trail <= c_trail + CW'(1);
      end else begin
        c_lead  <= c_lead - CW'(1);
        c_trail <= c_trail - CW'(1);
      end
    end else if (run) begin
      pre <= pre + PW'(1);
    end
  end
endmodule

// File: rtl/cpwm_phase.sv
module cpwm_phase #(
  parameter int unsigned CW = 16
) (
  input  logic          live,
  input  logic          pol_p,
  input  logic          pol_n,
  input  logic [CW-1:0] c_lead,
  input  logic [CW-1:0] c_trail,
  input  logic [CW-1:0] duty,
  output logic          pin_p,
  output logic          pin_n
);
  logic act_p, act_n;

  assign act_p = live && (c_trail >= duty);
  assign act_n = live && (c_lead < duty);
  assign pin_p = act_p ? pol_p : ~pol_p;
  assign pin_n = act_n ? pol_n : ~pol_n;
endmodule

// File: rtl/cpwm3_top.sv
module cpwm3_top
  import cpwm_pkg::*;
#(
  parameter int unsigned CW  = 16,
  parameter int unsigned PH  = 3,
  parameter int unsigned DIV = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [3:0]    wr_addr,
  input  logic [CW-1:0] wr_data,
  output logic [PH-1:0] pwm_p,
  output logic [PH-1:0] pwm_n,
  output logic          irq,
  output logic          cyc_tog
);
  logic                  run, start, out_en, irq_en, xfer, tick;
  logic                  crest_hit, trough_turn;
  mode_t                 mode;
  logic [CW-1:0]         dead, half_act, c_lead, c_trail;
  logic [PH-1:0][CW-1:0] duty_act;

  cpwm_regs #(.CW(CW), .PH(PH)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .xfer(xfer), .run(run), .start(start),
    .mode(mode), .out_en(out_en), .irq_en(irq_en), .dead(dead),
    .half_act(half_act), .duty_act(duty_act)
  );

  cpwm_counter #(.CW(CW), .DIV(DIV)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(run), .start(start), .dead(dead),
    .half(half_act), .c_lead(c_lead), .c_trail(c_trail), .tick(tick),
    .crest_hit(crest_hit), .trough_turn(trough_turn), .xfer(xfer)
  );

  for (genvar i = 0; i < PH; i++) begin : g_ph
    cpwm_phase #(.CW(CW)) u_ph (
      .live(run && out_en), .pol_p(mode.pol_p), .pol_n(mode.pol_n),
      .c_lead(c_lead), .c_trail(c_trail), .duty(duty_act[i]),
      .pin_p(pwm_p[i]), .pin_n(pwm_n[i])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq     <= 1'b0;
      cyc_tog <= 1'b0;
    end else begin
      irq <= irq_en && crest_hit;
      if (start) cyc_tog <= 1'b0;
      else if (trough_turn && mode.tog_en) cyc_tog <= ~cyc_tog;
    end
  end
endmodule

// File: rtl/cpwm_chk.sv
module cpwm_chk #(
  parameter int unsigned CW = 16,
  parameter int unsigned PH = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          run,
  input logic          start,
  input logic          tick,
  input logic          out_en,
  input logic          pol_p,
  input logic          pol_n,
  input logic [2:0]    mode_bits,
  input logic [CW-1:0] dead,
  input logic [CW-1:0] half_act,
  input logic [CW-1:0] c_lead,
  input logic [CW-1:0] c_trail,
  input logic [PH-1:0] pwm_p,
  input logic [PH-1:0] pwm_n,
  input logic          irq,
  input logic          cyc_tog
);
  logic [PH-1:0] on_p, on_n;
  assign on_p = pwm_p ~^ {PH{pol_p}};
  assign on_n = pwm_n ~^ {PH{pol_n}};

  AST_DEAD_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> ((c_lead - c_trail) == dead)); // R2

  AST_HOLD_HALTED: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !start) |=> ($stable(c_lead) && $stable(c_trail))); // R2

  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    (on_p & on_n) == '0); // R3

  AST_IDLE_PINS: assert property (@(posedge clk) disable iff (!rst_n)
    (!run || !out_en) |-> (on_p == '0 && on_n == '0)); // R5

  AST_LOCKED_CFG: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !start) |=> ($stable(mode_bits) && $stable(dead))); // R7

  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq); // R8

  AST_IRQ_AT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (c_lead == half_act + dead)); // R8

  AST_TOG_ON_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !start) |=> $stable(cyc_tog)); // R9
endmodule

bind cpwm3_top cpwm_chk #(.CW(CW), .PH(PH)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .start(start), .tick(tick),
  .out_en(out_en), .pol_p(mode.pol_p), .pol_n(mode.pol_n),
  .mode_bits(mode), .dead(dead), .half_act(half_act), .c_lead(c_lead),
  .c_trail(c_trail), .pwm_p(pwm_p), .pwm_n(pwm_n), .irq(irq),
  .cyc_tog(cyc_tog)
);

// File: tb/sim_cpwm3_top.sv
module sim_cpwm3_top;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 16;
  localparam int PH = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [3:0]    wr_addr = '0;
  logic [CW-1:0] wr_data = '0;
  logic [PH-1:0] pwm_p, pwm_n;
  logic          irq, cyc_tog;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int start_k = 0;

  // reference state
  int  mh, md;
  int  d1 [PH];
  int  d2 [PH];
  int  d3 [PH];
  int  sw1, sw2;
  bit  mrun, men, mirq, mtog, mpp, mpn;

  cpwm3_top #(.CW(CW), .PH(PH), .DIV(4)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .pwm_p(pwm_p), .pwm_n(pwm_n), .irq(irq),
    .cyc_tog(cyc_tog)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // R10: register map used by every scenario
  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 4'(a); wr_data = CW'(d);
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic start_run();
    wr(0, 1);
    start_k = cyc;
    mrun = 1'b1;
  endtask

  function automatic int duty_at(int ph, int n);
    if (n >= sw2) return d3[ph];
    if (n >= sw1) return d2[ph];
    return d1[ph];
  endfunction

  task automatic run_check(input int ncyc, input string tag, input bit chk_ev);
    for (int j = 0; j < ncyc; j++) begin
      int k, n, p, c2, c1, togc;
      logic [PH-1:0] ep, en;
      bit eirq;
      @(negedge clk);
      k = cyc - start_k;
      n = k / 4;
      p = n % (2*mh);
      c2 = (p <= mh) ? p : 2*mh - p;
      c1 = c2 + md;
      for (int i = 0; i < PH; i++) begin
        bit ap, an;
        ap = mrun && men && (c2 >= duty_at(i, n));
        an = mrun && men && (c1 < duty_at(i, n));
        ep[i] = ap ? mpp : ~mpp;
        en[i] = an ? mpn : ~mpn;
      end
      check({pwm_p, pwm_n} == {ep, en}, tag, int'({pwm_p, pwm_n}), int'({ep, en}));
      if (chk_ev) begin
        eirq = mirq && (k % 4 == 0) && (n >= mh) && ((n - mh) % (2*mh) == 0);
        check(irq == eirq, "R8 irq", int'(irq), int'(eirq));
        togc = (n >= 2*mh + 1) ? ((n - (2*mh + 1)) / (2*mh) + 1) : 0;
        check(cyc_tog == (mtog && togc[0]), "R9 cyc_tog", int'(cyc_tog), int'(mtog && togc[0]));
      end
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(pwm_p == '1 && pwm_n == '1, "R1 pins idle high", int'({pwm_p, pwm_n}), 63);
    check(irq == 1'b0, "R1 irq low", int'(irq), 0);
    check(cyc_tog == 1'b0, "R1 cyc_tog low", int'(cyc_tog), 0);
    repeat (6) @(negedge clk);
    check(pwm_p == '1 && pwm_n == '1, "R1 still halted", int'({pwm_p, pwm_n}), 63);
  endtask

  task automatic t_basic();
    wr(1, 7); wr(2, 2); wr(3, 6);
    wr(5, 1); wr(6, 4); wr(7, 7);
    wr(4, 3);
    mh = 6; md = 2; mpp = 1; mpn = 1; men = 1; mirq = 1; mtog = 1;
    d1 = '{1, 4, 7}; sw1 = 1 << 30; sw2 = 1 << 30;
    start_run();
    run_check(120, "R2 R3 compare", 1'b1);
  endtask

  task automatic t_ignore();
    wr(1, 6);   // R7 polarity/toggle write while running
    wr(2, 3);   // R7 dead-time write while running
    run_check(48, "R7 locked cfg", 1'b1);
  endtask

  task automatic t_master();
    wr(4, 2); men = 0;
    run_check(32, "R5 master off", 1'b1);
    wr(4, 3); men = 1;
    run_check(16, "R5 master on", 1'b1);
  endtask

  task automatic t_stop();
    wr(0, 0); mrun = 0;
    run_check(24, "R5 halted idle", 1'b0);
  endtask

  task automatic t_polarity();
    wr(1, 1); mpp = 0; mpn = 0;
    start_run();
    run_check(60, "R4 active-low", 1'b1);
  endtask

  task automatic t_xfer();
    wr(0, 0); mrun = 0;
    wr(5, 3); wr(6, 3); wr(7, 3);
    d1 = '{3, 3, 3}; d2 = '{5, 0, 2}; d3 = '{6, 6, 1};
    sw1 = mh + 1; sw2 = 2*mh + 1;
    start_run();
    wr(5, 5); wr(6, 0); wr(7, 2);
    run_check(20, "R6 crest transfer", 1'b1);
    run_check(17, "R6 crest transfer", 1'b1);
    wr(5, 6); wr(6, 6); wr(7, 1);
    run_check(44, "R6 trough transfer", 1'b1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    total++; bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    mrun = 0; men = 0; mirq = 0; mtog = 0; mpp = 0; mpn = 0;
    mh = 1; md = 1; sw1 = 1 << 30; sw2 = 1 << 30;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_basic();
    t_ignore();
    t_master();
    t_stop();
    t_polarity();
    t_xfer();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule